// File: doc/BRIEF.md
# Interleaved Stream Reassembly Controller

This block takes in a stream of 32-bit flits at up to one flit per clock. The stream carries packets from as many as 64 independent data streams, and packets of different streams may arrive interleaved. Each packet begins with three identity flits (source, destination, port) and a flag flit whose bit 0 marks the final packet of its stream. One or more data flits follow, and a closing flit ends the packet. The block finds which stream a packet belongs to by comparing its identity triple against an associative table. When the triple is not in the table, it claims the lowest-numbered free page for that stream. It then writes the data flits into a paged external memory at a per-page write offset, and that offset carries over from packet to packet.

When the closing flit of a final packet is accepted, the block queues a descriptor {page, length in flits} into a small output FIFO and drops the stream's table entry. The page stays reserved until a consumer acknowledges it by page number. After that, the page is free to be allocated again. The input stalls in two cases. The first is a closing flit that would push into a full FIFO. The second is a new stream that arrives when every page is reserved; in that case an overflow indication is raised as well.

Top module: `flit_reassembler`

## Requirements
- R1: After reset, no page is reserved and no table entry is valid, `in_ready` is 1, and `desc_valid`, `mem_we` and `err_overflow` are 0. A triple seen before the reset is treated as a new stream and starts at offset 0 of page 0.
- R2: `in_type` codes the flit kinds as 0 source, 1 destination, 2 port, 3 flag, 4 data and 5 close. A flit is consumed on each rising edge at which `in_valid` and `in_ready` are both 1.
- R3: A packet whose source, destination and port all equal those of a stream in progress uses that stream's page. A packet whose triple differs in any field gets a different page.
- R4: When a flag flit arrives for a triple that is not in the table, the lowest-numbered unreserved page is reserved for the stream, and the stream's write offset starts at 0.
- R5: Each accepted data flit of a packet produces one memory write on the following cycle. `mem_we` is 1, `mem_addr` is {page (upper 6 bits), offset (lower 11 bits)}, and `mem_wdata` is the flit.
- R6: The write offset of a page carries over between packets of the same stream, so their payloads are placed back to back.
- R7: When a close flit is accepted and the packet's flag bit 0 is 1, a descriptor with that page and the total number of data flits written to it is visible on `desc_*` from the next cycle. When the flag bit is 0, no descriptor is produced.
- R8: A close flit that needs to push a descriptor holds `in_ready` at 0 while the descriptor FIFO is full, and is accepted once a descriptor has been popped with `desc_valid` and `desc_ready` both 1. Descriptors leave the FIFO in completion order.
- R9: Completing a stream removes its table entry, so a later packet with the same triple opens a new page. An `ack_valid` pulse with `ack_page` releases that page for allocation.
- R10: A flag flit for a new triple that arrives while all pages are reserved holds `in_ready` at 0, and `err_overflow` is 1 from the next cycle. After a page is released, the flag flit is accepted onto that page and `err_overflow` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input flit present |
| in_type | input | 3 | Flit kind code |
| in_data | input | 32 | Flit payload |
| in_ready | output | 1 | Block can take the flit this cycle |
| mem_we | output | 1 | Data memory write strobe |
| mem_addr | output | 17 | Data memory address {page, offset} |
| mem_wdata | output | 32 | Data memory write data |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Consumer takes the descriptor |
| desc_page | output | 6 | Page of the completed stream |
| desc_len | output | 11 | Data flits in the completed stream |
| ack_valid | input | 1 | Consumer releases a page |
| ack_page | input | 6 | Page being released |
| err_overflow | output | 1 | New stream stalled for lack of a free page |

## Verification
`in_ready` is combinational, so the bench reads it 2 ns after driving a flit on the falling edge, which is before the next rising edge. A memory write appears one cycle after its data flit is accepted. The bench logs `mem_*` on every falling edge and later compares the address and data in the log with expected {page, offset} values. A descriptor and `err_overflow` are registered on the same edge that accepts the close flit or that sees the stall, so the bench checks them on the falling edge right after it, and checks a release one cycle after the `ack_valid` pulse.

// File: rtl/reasm_pkg.sv
package reasm_pkg;
  typedef enum logic [2:0] {
    FT_SRC  = 3'd0,
    FT_DST  = 3'd1,
    FT_PORT = 3'd2,
    FT_FLAG = 3'd3,
    FT_DATA = 3'd4,
    FT_CLOSE = 3'd5
  } flit_e;
endpackage

// File: rtl/reasm_lowest_free.sv
module reasm_lowest_free #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     used,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/reasm_match_table.sv
module reasm_match_table #(
  parameter int N = 64,
  parameter int KEY_W = 96,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [KEY_W-1:0] key,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [N-1:0]     inv_mask
);
  logic [KEY_W-1:0] keys [N];
  logic [N-1:0]     vld;
  logic [N-1:0]     hv;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hv[g] = vld[g] && (keys[g] == key);
  end

  assign hit = |hv;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hv[i]) hit_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= (vld & ~inv_mask) | (wr_en ? (N'(1) << wr_idx) : '0);
  end

  always_ff @(posedge clk) begin
    if (wr_en) keys[wr_idx] <= wr_key;
  end

  // R3: a triple never matches two live entries
  a_r3_single_hit: assert property (@(posedge clk) disable iff (rst) $onehot0(hv));
endmodule

// File: rtl/reasm_desc_fifo.sv
module reasm_desc_fifo #(
  parameter int W = 17,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             pop;

  assign full      = (count == CNT_W'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = slots[rd_ptr];
  assign pop       = out_valid && out_ready;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_data;
  end

  // R8: the controller never pushes into a full queue
  a_r8_push_not_full: assert property (@(posedge clk) disable iff (rst) push |-> (count < CNT_W'(DEPTH)));
endmodule

// File: rtl/flit_reassembler.sv
module flit_reassembler
  import reasm_pkg::*;
#(
  parameter int PAGES = 64,
  parameter int PAGE_FLITS = 2040,
  parameter int FLIT_W = 32,
  parameter int FIFO_DEPTH = 4,
  localparam int PAGE_W = $clog2(PAGES),
  localparam int OFF_W = $clog2(PAGE_FLITS),
  localparam int LEN_W = $clog2(PAGE_FLITS + 1),
  localparam int ADDR_W = PAGE_W + OFF_W,
  localparam int KEY_W = 3 * FLIT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_type,
  input  logic [FLIT_W-1:0] in_data,
  output logic              in_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [FLIT_W-1:0] mem_wdata,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [PAGE_W-1:0] desc_page,
  output logic [LEN_W-1:0]  desc_len,
  input  logic              ack_valid,
  input  logic [PAGE_W-1:0] ack_page,
  output logic              err_overflow
);
  flit_e             ft;
  logic [FLIT_W-1:0] src_q, dst_q, port_q;
  logic [KEY_W-1:0]  key;
  logic [PAGE_W-1:0] cur_page;
  logic              cur_valid, cur_last;
  logic [PAGES-1:0]  used_q;
  logic [LEN_W-1:0]  wptr [PAGES];
  logic              hit, found, fifo_full, accept, push, alloc, no_page;
  logic [PAGE_W-1:0] hit_idx, free_idx;
  logic [PAGES-1:0]  inv_mask;

  assign ft  = flit_e'(in_type);
  assign key = {src_q, dst_q, port_q};

  reasm_match_table #(.N(PAGES), .KEY_W(KEY_W)) u_table (
    .clk(clk), .rst(rst), .key(key), .hit(hit), .hit_idx(hit_idx),
    .wr_en(alloc), .wr_idx(free_idx), .wr_key(key), .inv_mask(inv_mask)
  );

  reasm_lowest_free #(.N(PAGES)) u_free (
    .used(used_q), .found(found), .idx(free_idx)
  );

  reasm_desc_fifo #(.W(PAGE_W + LEN_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data({cur_page, wptr[cur_page]}),
    .full(fifo_full), .out_valid(desc_valid), .out_ready(desc_ready),
    .out_data({desc_page, desc_len})
  );

  assign no_page  = (ft == FT_FLAG) && !hit && !found;
  assign in_ready = !no_page && !((ft == FT_CLOSE) && cur_valid && cur_last && fifo_full);
  assign accept   = in_valid && in_ready;
  assign alloc    = accept && (ft == FT_FLAG) && !hit;
  assign push     = accept && (ft == FT_CLOSE) && cur_valid && cur_last;
  assign inv_mask = (push ? (PAGES'(1) << cur_page) : '0)
                  | (ack_valid ? (PAGES'(1) << ack_page) : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q        <= '0;
      dst_q        <= '0;
      port_q       <= '0;
      cur_page     <= '0;
      cur_valid    <= 1'b0;
      cur_last     <= 1'b0;
      used_q       <= '0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      err_overflow <= 1'b0;
    end else begin
      err_overflow <= in_valid && no_page;
      mem_we       <= 1'b0;
      if (ack_valid) used_q[ack_page] <= 1'b0;
      if (alloc)     used_q[free_idx] <= 1'b1;
      if (accept) begin
        case (ft)
          FT_SRC:  src_q  <= in_data;
          FT_DST:  dst_q  <= in_data;
          FT_PORT: port_q <= in_data;
          FT_FLAG: begin
            cur_valid <= 1'b1;
            cur_last  <= in_data[0];
            cur_page  <= hit ? hit_idx : free_idx;
          end
          FT_DATA: begin
            if (cur_valid && (wptr[cur_page] < LEN_W'(PAGE_FLITS))) begin
              mem_we    <= 1'b1;
              mem_addr  <= {cur_page, OFF_W'(wptr[cur_page])};
              mem_wdata <= in_data;
            end
          end
          FT_CLOSE: cur_valid <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      wptr[free_idx] <= '0;
    end else if (accept && (ft == FT_DATA) && cur_valid &&
                 (wptr[cur_page] < LEN_W'(PAGE_FLITS))) begin
      wptr[cur_page] <= wptr[cur_page] + 1'b1;
    end
  end

  // R5: a memory write only follows an accepted data flit
  a_r5_write_after_data: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(in_valid && in_ready && (in_type == 3'd4)));
  // R10: the overflow flag reports a stall of the previous cycle
  a_r10_err_after_stall: assert property (@(posedge clk) disable iff (rst)
    err_overflow |-> $past(in_valid && !in_ready));
  // R9: an acknowledged page is unreserved afterwards
  a_r9_ack_frees: assert property (@(posedge clk) disable iff (rst)
    ack_valid |=> !used_q[$past(ack_page)]);
endmodule

// File: tb/sim_flit_reassembler.sv
`timescale 1ns/1ps
module sim_flit_reassembler;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_type = 3'd0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        mem_we;
  logic [16:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        desc_valid;
  logic        desc_ready = 1'b0;
  logic [5:0]  desc_page;
  logic [10:0] desc_len;
  logic        ack_valid = 1'b0;
  logic [5:0]  ack_page = '0;
  logic        err_overflow;

  int checks = 0;
  int fails  = 0;
  logic [16:0] log_addr [512];
  logic [31:0] log_data [512];
  int wcount = 0;

  always #5 clk = ~clk;

  flit_reassembler u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_type(in_type), .in_data(in_data),
    .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_page(desc_page),
    .desc_len(desc_len), .ack_valid(ack_valid), .ack_page(ack_page),
    .err_overflow(err_overflow)
  );

  always @(negedge clk) begin
    if (!rst && mem_we && wcount < 512) begin
      log_addr[wcount] = mem_addr;
      log_data[wcount] = mem_wdata;
      wcount++;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_eq(input string tag, input longint act, input longint exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; desc_ready = 1'b0; ack_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic present(input logic [2:0] t, input logic [31:0] d);
    in_valid = 1'b1; in_type = t; in_data = d;
  endtask

  // caller is at a falling edge with the flit driven; returns at the falling edge after acceptance
  task automatic wait_accept();
    bit done = 1'b0;
    while (!done) begin
      #2;
      done = in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic send(input logic [2:0] t, input logic [31:0] d);
    present(t, d);
    wait_accept();
  endtask

  task automatic send_header(input int k, input bit last);
    send(3'd0, 32'h1000_0000 + k);
    send(3'd1, 32'h2000_0000 + k);
    send(3'd2, 32'h0000_0000 + k);
    send(3'd3, {31'd0, last});
  endtask

  task automatic send_pkt(input int k, input bit last, input int n, input logic [31:0] base);
    send_header(k, last);
    for (int i = 0; i < n; i++) send(3'd4, base + i);
    send(3'd5, 32'd0);
  endtask

  task automatic pop_desc();
    desc_ready = 1'b1;
    @(negedge clk);
    desc_ready = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    #2;
    check_eq("R1 in_ready", in_ready, 1);
    check_eq("R1 desc_valid", desc_valid, 0);
    check_eq("R1 mem_we", mem_we, 0);
    check_eq("R1 err_overflow", err_overflow, 0);
  endtask

  task automatic t_single_stream();
    int w0;
    do_reset();
    w0 = wcount;
    send_pkt(1, 1'b1, 3, 32'hA0);
    check_eq("R5 write count", wcount - w0, 3);
    for (int i = 0; i < 3; i++) begin
      check_eq("R5 addr", log_addr[w0 + i], i);
      check_eq("R2 data", log_data[w0 + i], 32'hA0 + i);
    end
    check_eq("R7 desc_valid", desc_valid, 1);
    check_eq("R7 desc_page", desc_page, 0);
    check_eq("R7 desc_len", desc_len, 3);
    pop_desc();
    check_eq("R8 popped", desc_valid, 0);
  endtask

  task automatic t_interleave();
    int w0;
    do_reset();
    w0 = wcount;
    send_pkt(1, 1'b0, 2, 32'hB0);
    check_eq("R1 page0 after reset", log_addr[w0], 0);
    send_pkt(2, 1'b0, 1, 32'hC0);
    check_eq("R3 other triple page1", log_addr[w0 + 2], 17'd2048);
    check_eq("R7 no desc without flag", desc_valid, 0);
    send_pkt(1, 1'b1, 2, 32'hB2);
    check_eq("R6 concat off2", log_addr[w0 + 3], 2);
    check_eq("R6 concat off3", log_addr[w0 + 4], 3);
    check_eq("R3 same page", log_data[w0 + 4], 32'hB3);
    check_eq("R7 desc page", desc_page, 0);
    check_eq("R6 desc len", desc_len, 4);
    pop_desc();
    send_pkt(1, 1'b0, 1, 32'hD0);
    check_eq("R9 reopened on page2", log_addr[w0 + 5], {6'd2, 11'd0});
    ack_valid = 1'b1; ack_page = 6'd0;
    @(negedge clk);
    ack_valid = 1'b0;
    send_pkt(3, 1'b0, 1, 32'hE0);
    check_eq("R4 lowest free after ack", log_addr[w0 + 6], {6'd0, 11'd0});
  endtask

  task automatic t_backpressure();
    int w0;
    do_reset();
    for (int k = 0; k < 4; k++) send_pkt(10 + k, 1'b1, 1, 32'h100 + k);
    check_eq("R8 queue holds", desc_valid, 1);
    w0 = wcount;
    send_header(20, 1'b1);
    send(3'd4, 32'h200);
    present(3'd5, 32'd0);
    #2;
    check_eq("R8 stall on full", in_ready, 0);
    @(negedge clk); @(negedge clk); @(negedge clk);
    #2;
    check_eq("R8 still stalled", in_ready, 0);
    @(negedge clk);
    check_eq("R8 first out page0", desc_page, 0);
    in_valid = 1'b0;
    pop_desc();
    present(3'd5, 32'd0);
    wait_accept();
    check_eq("R4 fifth page", log_addr[w0] >> 11, 4);
    for (int k = 1; k <= 4; k++) begin
      check_eq("R8 order", desc_page, k);
      pop_desc();
    end
    check_eq("R8 drained", desc_valid, 0);
  endtask

  task automatic t_overflow();
    int w0;
    do_reset();
    for (int k = 0; k < 64; k++) send_pkt(100 + k, 1'b0, 1, k);
    check_eq("R4 last page 63", log_addr[wcount - 1], {6'd63, 11'd0});
    send(3'd0, 32'h5555_0001);
    send(3'd1, 32'h5555_0002);
    send(3'd2, 32'h5555_0003);
    present(3'd3, 32'd1);
    #2;
    check_eq("R10 stall no page", in_ready, 0);
    @(negedge clk);
    check_eq("R10 err set", err_overflow, 1);
    ack_valid = 1'b1; ack_page = 6'd5;
    @(negedge clk);
    ack_valid = 1'b0;
    wait_accept();
    check_eq("R10 err cleared", err_overflow, 0);
    w0 = wcount;
    send(3'd4, 32'hF00D);
    send(3'd5, 32'd0);
    check_eq("R10 released page used", log_addr[w0], {6'd5, 11'd0});
    check_eq("R7 desc for released page", desc_page, 5);
    check_eq("R7 len one", desc_len, 1);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_single_stream();
    t_interleave();
    t_backpressure();
    t_overflow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule